// File: doc/BRIEF.md
# Repeating SPI Shift Sequencer

This block is an SPI master controlled through a byte-wide register window. Software loads a transmit byte memory and sets a bit count. The block then clocks that many bits out on the serial output, most significant bit of each byte first. It captures the bits returned on the serial input into a receive byte memory, using the same bit positions. One pass is a single run of the programmed bit count with the active-low select held low. The block repeats the pass a programmed number of times, or without end, and leaves a programmable idle gap between passes.

A transfer starts in one of two ways. Software writes to the start register, or the external start input pulses while the enable bit is set. A ready flag in the register window reads 1 whenever the sequencer is idle. Writing to the reset register aborts any activity at once. The configuration registers and the memories keep their contents through this abort. The shift clock runs at half the system clock. Data changes as the shift clock goes low and is sampled as the shift clock goes high.

Top module: `rep_spi_seq`

## Requirements
- R1: After reset the select is high, the shift clock is low and ready is 1. Byte address 0 reads the version value 2. Addresses 14 (low byte) and 15 (high byte) read the memory size in bytes.
- R2: Bit 0 at address 1 reads 0 from the cycle after a start is accepted until the last pass ends. It returns to 1 on the same clock edge at which the select rises after that final pass.
- R3: Each pass gives exactly SIZE shift-clock high pulses. Each high phase and each low phase lasts one system cycle. The shift clock is high only while the select is low.
- R4: Bit i of a pass is driven on the serial output from bit 7-(i mod 8) of transmit byte i/8. Transmit memory starts at byte address 16. The output does not change while the shift clock is high.
- R5: The serial input, sampled at the system edge where the shift clock rises, is written to bit 7-(i mod 8) of receive byte i/8. Receive memory starts at byte address 16+MEM_BYTES. Receive bits outside the pass keep their previous values.
- R6: Between two passes the select stays high for exactly WAIT+1 system cycles.
- R7: REPEAT (addresses 9..12) sets the number of passes. A value of 0 keeps the passes running until a soft reset.
- R8: A start from either source that arrives while a transfer is active has no effect on the pass count or the bit count.
- R9: A write of any value to address 0 forces the select high, the shift clock low and ready to 1 on the next cycle. SIZE, WAIT and REPEAT keep their values.
- R10: A one-cycle pulse on the external start input begins a transfer only when bit 0 of address 13 is 1. With that bit at 0 the pulse is ignored.
- R11: A start with SIZE (addresses 3..4) equal to 0 is ignored, and ready stays 1.
- R12: SIZE, WAIT (addresses 5..8) and REPEAT are little-endian, with the lowest address holding bits 7:0. All three read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | BUS_AW | Register window byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe, one cycle per byte |
| bus_rdata_o | output | 8 | Combinational read data for bus_addr_i |
| ext_start_i | input | 1 | External start pulse, honoured when enabled |
| sck_o | output | 1 | Shift clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Active-low select, low during each pass |

## Verification
Two situations are the hardest to reach from the ports. One is an endless repeat run that must be aborted partway through a pass. The other is the idle gap between passes, which only exists when REPEAT is above 1. The stimulus programs REPEAT to 0 and lets many passes go by. It then writes the reset register while the select is low and checks that the outputs settle and the shift-clock count stops growing. A table of multi-pass cases with different WAIT values exposes the gap length. A monitor measures the gap as the length of the select-high run before each falling edge of the select. The serial input is looped back inverted, so the receive memory contents show both the bit order and the sampling point.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_e;

  localparam logic [7:0] SEQ_VERSION = 8'd2;

  // register window byte addresses
  localparam int ADR_CTRL   = 0;
  localparam int ADR_GO     = 1;
  localparam int ADR_SIZE   = 3;
  localparam int ADR_GAP    = 5;
  localparam int ADR_REP    = 9;
  localparam int ADR_EN     = 13;
  localparam int ADR_MSIZE  = 14;
  localparam int ADR_TXBASE = 16;

endpackage

// File: rtl/spi_seq_bytemem.sv
module spi_seq_bytemem #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int NRD   = 1
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [7:0]              wmask_i,
  input  logic [7:0]              wdata_i,
  input  logic [NRD-1:0][AW-1:0]  raddr_i,
  output logic [NRD-1:0][7:0]     rdata_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < 8; b++) begin
        if (wmask_i[b]) mem_q[waddr_i][b] <= wdata_i[b];
      end
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end

endmodule

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
  import spi_seq_pkg::*;
#(
  parameter int MEM_BYTES = 16,
  parameter int MEM_AW    = 4,
  parameter int BUS_AW    = 6,
  parameter int SIZE_W    = 16,
  parameter int CNT_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  input  logic              bus_we_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              ext_start_i,
  input  logic              ready_i,
  input  logic [7:0]        tx_rdata_i,
  input  logic [7:0]        rx_rdata_i,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              tx_we_o,
  output logic              soft_rst_o,
  output logic              start_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [CNT_W-1:0]  gap_o,
  output logic [CNT_W-1:0]  rep_o
);

  localparam int RX_BASE  = ADR_TXBASE + MEM_BYTES;
  localparam int RX_END   = RX_BASE + MEM_BYTES;
  localparam int SIZE_NB  = SIZE_W / 8;
  localparam int CNT_NB   = CNT_W / 8;
  localparam logic [15:0] MSIZE = 16'(MEM_BYTES);

  logic [31:0] addr_w;
  logic        in_tx, in_rx, en_q;
  logic [SIZE_W-1:0] size_q;
  logic [CNT_W-1:0]  gap_q, rep_q;

  assign addr_w = 32'(bus_addr_i);
  assign in_tx  = (addr_w >= 32'(ADR_TXBASE)) && (addr_w < 32'(RX_BASE));
  assign in_rx  = (addr_w >= 32'(RX_BASE)) && (addr_w < 32'(RX_END));

  assign mem_addr_o = in_rx ? MEM_AW'(addr_w - 32'(RX_BASE))
                            : MEM_AW'(addr_w - 32'(ADR_TXBASE));
  assign tx_we_o    = bus_we_i && in_tx;
  assign soft_rst_o = bus_we_i && (addr_w == 32'(ADR_CTRL));
  assign start_o    = (bus_we_i && (addr_w == 32'(ADR_GO))) || (en_q && ext_start_i);

  assign size_o = size_q;
  assign gap_o  = gap_q;
  assign rep_o  = rep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= '0;
      gap_q  <= '0;
      rep_q  <= CNT_W'(1);
      en_q   <= 1'b0;
    end else if (bus_we_i) begin
      for (int k = 0; k < SIZE_NB; k++)
        if (addr_w == 32'(ADR_SIZE + k)) size_q[8*k +: 8] <= bus_wdata_i;
      for (int k = 0; k < CNT_NB; k++) begin
        if (addr_w == 32'(ADR_GAP + k)) gap_q[8*k +: 8] <= bus_wdata_i;
        if (addr_w == 32'(ADR_REP + k)) rep_q[8*k +: 8] <= bus_wdata_i;
      end
      if (addr_w == 32'(ADR_EN)) en_q <= bus_wdata_i[0];
    end
  end

  always_comb begin
    bus_rdata_o = 8'h00;
    if (addr_w == 32'(ADR_CTRL)) bus_rdata_o = SEQ_VERSION;
    if (addr_w == 32'(ADR_GO))   bus_rdata_o = {7'd0, ready_i};
    for (int k = 0; k < SIZE_NB; k++)
      if (addr_w == 32'(ADR_SIZE + k)) bus_rdata_o = size_q[8*k +: 8];
    for (int k = 0; k < CNT_NB; k++) begin
      if (addr_w == 32'(ADR_GAP + k)) bus_rdata_o = gap_q[8*k +: 8];
      if (addr_w == 32'(ADR_REP + k)) bus_rdata_o = rep_q[8*k +: 8];
    end
    if (addr_w == 32'(ADR_EN))        bus_rdata_o = {7'd0, en_q};
    if (addr_w == 32'(ADR_MSIZE))     bus_rdata_o = MSIZE[7:0];
    if (addr_w == 32'(ADR_MSIZE + 1)) bus_rdata_o = MSIZE[15:8];
    if (in_tx) bus_rdata_o = tx_rdata_i;
    if (in_rx) bus_rdata_o = rx_rdata_i;
  end

endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int MEM_AW = 4,
  parameter int SIZE_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [CNT_W-1:0]  gap_i,
  input  logic [CNT_W-1:0]  rep_i,
  input  logic [7:0]        tx_rdata_i,
  output logic [MEM_AW-1:0] tx_raddr_o,
  output logic              rx_we_o,
  output logic [MEM_AW-1:0] rx_waddr_o,
  output logic [7:0]        rx_wmask_o,
  output logic [7:0]        rx_wdata_o,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              cs_no,
  output logic              ready_o
);

  seq_state_e        state_q;
  logic [SIZE_W-1:0] bit_q, size_q, nxt_bit;
  logic [CNT_W-1:0]  pass_q, gap_cnt_q, gap_q, rep_q;
  logic              phase_q, sck_q, cs_nq, mosi_q;
  logic              nxt_mosi, last_bit, last_pass, start_ok;

  // bit to present at the next falling shift-clock edge
  assign nxt_bit    = (state_q == ST_SHIFT) ? bit_q + SIZE_W'(1) : '0;
  assign tx_raddr_o = MEM_AW'(nxt_bit >> 3);
  assign nxt_mosi   = tx_rdata_i[3'd7 - nxt_bit[2:0]];

  assign last_bit  = (bit_q == size_q - SIZE_W'(1));
  assign last_pass = (rep_q != '0) && (pass_q == rep_q - CNT_W'(1));
  assign start_ok  = start_i && (state_q == ST_IDLE) && (size_i != '0);

  assign rx_we_o    = (state_q == ST_SHIFT) && !phase_q;
  assign rx_waddr_o = MEM_AW'(bit_q >> 3);
  assign rx_wmask_o = 8'h80 >> bit_q[2:0];
  assign rx_wdata_o = {8{miso_i}};

  assign sck_o   = sck_q;
  assign mosi_o  = mosi_q;
  assign cs_no   = cs_nq;
  assign ready_o = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      size_q    <= '0;
      pass_q    <= '0;
      gap_cnt_q <= '0;
      gap_q     <= '0;
      rep_q     <= '0;
      phase_q   <= 1'b0;
      sck_q     <= 1'b0;
      cs_nq     <= 1'b1;
      mosi_q    <= 1'b0;
    end else if (soft_rst_i) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      sck_q   <= 1'b0;
      cs_nq   <= 1'b1;
      mosi_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            state_q <= ST_SHIFT;
            size_q  <= size_i;
            gap_q   <= gap_i;
            rep_q   <= rep_i;
            pass_q  <= '0;
            bit_q   <= '0;
            phase_q <= 1'b0;
            cs_nq   <= 1'b0;
            mosi_q  <= nxt_mosi;
          end
        end
        ST_SHIFT: begin
          if (!phase_q) begin
            phase_q <= 1'b1;
            sck_q   <= 1'b1;
          end else begin
            phase_q <= 1'b0;
            sck_q   <= 1'b0;
            if (last_bit) begin
              cs_nq  <= 1'b1;
              mosi_q <= 1'b0;
              if (last_pass) begin
                state_q <= ST_IDLE;
              end else begin
                state_q   <= ST_GAP;
                pass_q    <= pass_q + CNT_W'(1);
                gap_cnt_q <= gap_q;
              end
            end else begin
              bit_q  <= bit_q + SIZE_W'(1);
              mosi_q <= nxt_mosi;
            end
          end
        end
        ST_GAP: begin
          if (gap_cnt_q == '0) begin
            state_q <= ST_SHIFT;
            bit_q   <= '0;
            phase_q <= 1'b0;
            cs_nq   <= 1'b0;
            mosi_q  <= nxt_mosi;
          end else begin
            gap_cnt_q <= gap_cnt_q - CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rep_spi_seq.sv
module rep_spi_seq
  import spi_seq_pkg::*;
#(
  parameter int MEM_BYTES = 16,
  parameter int SIZE_W    = 16,
  parameter int CNT_W     = 32,
  parameter int MEM_AW    = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1,
  parameter int BUS_AW    = $clog2(ADR_TXBASE + 2 * MEM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  input  logic              bus_we_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              ext_start_i,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no
);

  logic [MEM_AW-1:0] mem_addr, eng_tx_addr, rx_waddr;
  logic              tx_we, soft_rst, start, ready, rx_we;
  logic [7:0]        rx_wmask, rx_wdata;
  logic [SIZE_W-1:0] size;
  logic [CNT_W-1:0]  gap, rep;
  logic [1:0][MEM_AW-1:0] tx_raddr;
  logic [1:0][7:0]        tx_rdata;
  logic [0:0][MEM_AW-1:0] rx_raddr;
  logic [0:0][7:0]        rx_rdata;

  assign tx_raddr[0] = mem_addr;
  assign tx_raddr[1] = eng_tx_addr;
  assign rx_raddr[0] = mem_addr;

  spi_seq_regs #(
    .MEM_BYTES(MEM_BYTES), .MEM_AW(MEM_AW), .BUS_AW(BUS_AW),
    .SIZE_W(SIZE_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk_i, .rst_ni, .bus_addr_i, .bus_wdata_i, .bus_we_i, .bus_rdata_o,
    .ext_start_i,
    .ready_i    (ready),
    .tx_rdata_i (tx_rdata[0]),
    .rx_rdata_i (rx_rdata[0]),
    .mem_addr_o (mem_addr),
    .tx_we_o    (tx_we),
    .soft_rst_o (soft_rst),
    .start_o    (start),
    .size_o     (size),
    .gap_o      (gap),
    .rep_o      (rep)
  );

  spi_seq_bytemem #(.DEPTH(MEM_BYTES), .AW(MEM_AW), .NRD(2)) u_txmem (
    .clk_i,
    .we_i    (tx_we),
    .waddr_i (mem_addr),
    .wmask_i (8'hFF),
    .wdata_i (bus_wdata_i),
    .raddr_i (tx_raddr),
    .rdata_o (tx_rdata)
  );

  spi_seq_bytemem #(.DEPTH(MEM_BYTES), .AW(MEM_AW), .NRD(1)) u_rxmem (
    .clk_i,
    .we_i    (rx_we),
    .waddr_i (rx_waddr),
    .wmask_i (rx_wmask),
    .wdata_i (rx_wdata),
    .raddr_i (rx_raddr),
    .rdata_o (rx_rdata)
  );

  spi_seq_engine #(.MEM_AW(MEM_AW), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_eng (
    .clk_i, .rst_ni,
    .soft_rst_i (soft_rst),
    .start_i    (start),
    .size_i     (size),
    .gap_i      (gap),
    .rep_i      (rep),
    .tx_rdata_i (tx_rdata[1]),
    .tx_raddr_o (eng_tx_addr),
    .rx_we_o    (rx_we),
    .rx_waddr_o (rx_waddr),
    .rx_wmask_o (rx_wmask),
    .rx_wdata_o (rx_wdata),
    .miso_i,
    .sck_o, .mosi_o, .cs_no,
    .ready_o    (ready)
  );

endmodule

// File: rtl/spi_seq_checker.sv
module spi_seq_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sck_i,
  input logic cs_ni,
  input logic mosi_i,
  input logic ready_i,
  input logic soft_rst_i
);

  // R3: shift clock only inside a pass
  a_r3_sck_in_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_i |-> !cs_ni);

  // R3: high phase lasts one cycle
  a_r3_sck_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_i |=> !sck_i);

  // R4: data held while clock high
  a_r4_mosi_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_i) |-> $stable(mosi_i));

  // R2: ready low whenever a pass is active
  a_r2_busy_when_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ni |-> !ready_i);

  // R9: abort settles outputs next cycle
  a_r9_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (cs_ni && !sck_i && ready_i));

endmodule

bind rep_spi_seq spi_seq_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sck_i      (sck_o),
  .cs_ni      (cs_no),
  .mosi_i     (mosi_o),
  .ready_i    (ready),
  .soft_rst_i (soft_rst)
);

// File: tb/rep_spi_seq_tb.sv
`timescale 1ns/1ps
module rep_spi_seq_tb;
  localparam int MEMB = 16;
  localparam int AW   = $clog2(16 + 2 * MEMB);
  localparam int RXB  = 16 + MEMB;

  typedef struct packed {
    logic [15:0] size;
    logic [31:0] gap;
    logic [31:0] rep;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{size: 16'd8,  gap: 32'd0, rep: 32'd1},
    '{size: 16'd12, gap: 32'd3, rep: 32'd2},
    '{size: 16'd5,  gap: 32'd7, rep: 32'd3},
    '{size: 16'd20, gap: 32'd1, rep: 32'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic we = 1'b0, ext = 1'b0;
  logic sck, mosi, miso, cs_n;

  always #2.5 clk = ~clk;

  rep_spi_seq #(.MEM_BYTES(MEMB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_we_i(we), .bus_rdata_o(rdata), .ext_start_i(ext),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  assign miso = ~mosi;

  int total = 0, fails = 0;
  int sck_n = 0, pass_n = 0, hi_run = 0, last_gap = 0;
  logic mosi_log [512];
  bit done = 0;

  always @(posedge sck) begin
    if (sck_n < 512) mosi_log[sck_n] = mosi;
    sck_n++;
  end
  always @(negedge cs_n) pass_n++;
  always @(negedge clk) begin
    if (cs_n) hi_run++;
    else if (hi_run != 0) begin last_gap = hi_run; hi_run = 0; end
  end

  function automatic logic [7:0] txb(int k);
    return 8'((k * 37) ^ 8'h3C);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = AW'(a);
    #0.5 d = rdata;
  endtask

  task automatic wr_n(input int a, input logic [31:0] v, input int nb);
    for (int k = 0; k < nb; k++) bus_wr(a + k, v[8*k +: 8]);
  endtask

  task automatic wait_ready();
    logic [7:0] r;
    for (int i = 0; i < 20000; i++) begin
      bus_rd(1, r);
      if (r[0]) return;
    end
  endtask

  task automatic clear_mon();
    sck_n = 0; pass_n = 0; last_gap = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    int bad;
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cs_n", 32'(cs_n), 1);
    check("R1 sck", 32'(sck), 0);
    bus_rd(1, r); check("R1 ready", 32'(r[0]), 1);
    bus_rd(0, r); check("R1 version", 32'(r), 2);
    bus_rd(14, r); check("R1 memsize lo", 32'(r), MEMB & 255);
    bus_rd(15, r); check("R1 memsize hi", 32'(r), MEMB >> 8);

    for (int k = 0; k < MEMB; k++) bus_wr(16 + k, txb(k));

    // R12 little-endian readback
    wr_n(5, 32'h44332211, 4);
    bus_rd(5, r); check("R12 wait b0", 32'(r), 32'h11);
    bus_rd(8, r); check("R12 wait b3", 32'(r), 32'h44);
    wr_n(3, 32'h0000A1B2, 2);
    bus_rd(3, r); check("R12 size b0", 32'(r), 32'hB2);
    bus_rd(4, r); check("R12 size b1", 32'(r), 32'hA1);

    // table of passes: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 4; v++) begin
      wr_n(3, 32'(VECS[v].size), 2);
      wr_n(5, VECS[v].gap, 4);
      wr_n(9, VECS[v].rep, 4);
      clear_mon();
      bus_wr(1, 8'h00);
      bus_rd(1, r); check("R2 busy", 32'(r[0]), 0);
      wait_ready();
      check("R3 sck pulses", 32'(sck_n), 32'(VECS[v].size) * VECS[v].rep);
      check("R7 passes", 32'(pass_n), VECS[v].rep);
      if (VECS[v].rep > 1) check("R6 gap", 32'(last_gap), VECS[v].gap + 1);
      bad = 0;
      for (int i = 0; i < int'(VECS[v].size); i++) begin
        logic [7:0] t;
        t = txb(i / 8);
        if (mosi_log[i] !== t[7 - i % 8]) bad++;
      end
      check("R4 mosi order", 32'(bad), 0);
      bad = 0;
      for (int i = 0; i < int'(VECS[v].size); i++) begin
        logic [7:0] t;
        t = txb(i / 8);
        bus_rd(RXB + i / 8, r);
        if (r[7 - i % 8] !== ~t[7 - i % 8]) bad++;
      end
      check("R5 rx capture", 32'(bad), 0);
    end

    // R8 start while busy ignored
    wr_n(3, 32'd6, 2); wr_n(5, 32'd0, 4); wr_n(9, 32'd1, 4);
    bus_wr(13, 8'h01);
    clear_mon();
    bus_wr(1, 8'h00);
    bus_wr(1, 8'h00);
    @(negedge clk); ext = 1'b1; @(negedge clk); ext = 1'b0;
    wait_ready();
    check("R8 passes", 32'(pass_n), 1);
    check("R8 sck", 32'(sck_n), 6);

    // R10 external start
    bus_wr(13, 8'h00);
    clear_mon();
    @(negedge clk); ext = 1'b1; @(negedge clk); ext = 1'b0;
    repeat (10) @(negedge clk);
    bus_rd(1, r);
    check("R10 disabled ready", 32'(r[0]), 1);
    check("R10 disabled sck", 32'(sck_n), 0);
    bus_wr(13, 8'h01);
    @(negedge clk); ext = 1'b1; @(negedge clk); ext = 1'b0;
    wait_ready();
    check("R10 enabled passes", 32'(pass_n), 1);
    bus_wr(13, 8'h00);

    // R11 size zero
    wr_n(3, 32'd0, 2);
    clear_mon();
    bus_wr(1, 8'h00);
    repeat (10) @(negedge clk);
    bus_rd(1, r);
    check("R11 ready", 32'(r[0]), 1);
    check("R11 sck", 32'(sck_n), 0);

    // R7 forever, then R9 soft reset
    wr_n(3, 32'd4, 2); wr_n(9, 32'd0, 4);
    clear_mon();
    bus_wr(1, 8'h00);
    repeat (200) @(negedge clk);
    bus_rd(1, r);
    check("R7 forever busy", 32'(r[0]), 0);
    check("R7 forever many passes", 32'(pass_n > 10), 1);
    while (cs_n) @(negedge clk);
    bus_wr(0, 8'h5A);
    check("R9 cs_n", 32'(cs_n), 1);
    check("R9 sck", 32'(sck), 0);
    bus_rd(1, r); check("R9 ready", 32'(r[0]), 1);
    snap = sck_n;
    repeat (20) @(negedge clk);
    check("R9 stopped", 32'(sck_n), 32'(snap));
    bus_rd(3, r); check("R9 size kept", 32'(r), 4);

    done = 1;
    finish_run();
  end
endmodule